// File: doc/BRIEF.md
# Single-Wait-State Register Slave

This block is a small register peripheral on an APB4 bus. Every transfer it accepts gets exactly one wait state: a two-state sequencer sees the first access cycle, and in the next cycle a registered ready line completes the transfer. The write commit, the read data and the error response all belong to that completing cycle. So a slow bus segment can reach the registers without a combinational path from the select inputs to the ready output.

Behind the bus sits a map of four 32-bit words. One is a control word that software reads and writes and hardware consumes. One is a status word copied from hardware. One is an interrupt-flag word that software clears by writing ones. The last is a command location whose writes send a single-cycle strobe to hardware. Any other word offset answers with an error response and read data of zero.

Top module: `apbw_slave`

## Requirements
- R1: While `presetn` is low at a rising clock edge, every register clears to zero. During reset `pready`, `pslverr`, `prdata`, `ctrl_out` and `cmd_strobe` all read zero.
- R2: In the first cycle with `psel` and `penable` both high, `pready` is low. It is high in the next cycle, which completes the transfer, and low in the cycle after that. Every transfer therefore has exactly one wait cycle.
- R3: The decoder uses only the word index `paddr[ADDR_W-1:2]` and ignores bits [1:0]. Index 0 (offset 0x00) is control, 1 (0x04) is status, 2 (0x08) is flags and 3 (0x0C) is command. Every other index is a decode miss.
- R4: A completed write to control replaces byte lane i (bits 8i+7..8i) with the matching byte of `pwdata` only when `pstrb[i]` is 1. The other lanes keep their value. The new value is visible on `ctrl_out` from the cycle after completion.
- R5: A read of status returns `hw_status` as sampled at the previous clock edge. A write to status changes nothing and gets no error response.
- R6: A `hw_event` pulse sets bit 0 of the flag word. A completed write clears each flag bit that has a 1 in `pwdata` within a lane whose strobe is set. If a set and a clear of bit 0 fall in the same cycle, the bit ends up 1.
- R7: A completed write to command raises `cmd_strobe` for exactly the one cycle after completion. A read of command returns zero.
- R8: In the completing cycle of a read, `prdata` holds the addressed register. A read of an unmapped offset returns zero.
- R9: `pslverr` is high only in the completing cycle of a transfer to an unmapped offset. A write to an unmapped offset changes no register.
- R10: If `psel` falls before the completing cycle, nothing is committed. The next transfer again gets exactly one wait cycle.
- R11: Back-to-back transfers are supported: `psel` stays high and `penable` drops for one setup cycle between them. Each transfer gets its own single wait cycle and its own commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| presetn | input | 1 | Reset, active low, sampled on the clock |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, driven from a register |
| pslverr | output | 1 | Error response for an unmapped offset |
| hw_status | input | 32 | Status word from hardware |
| hw_event | input | 1 | Sets flag bit 0 |
| ctrl_out | output | 32 | Control word to hardware |
| cmd_strobe | output | 1 | One-cycle command pulse |

## Verification
The bench builds the slave with `ADDR_W = 6`, so the address space holds sixteen word indices. That puts unmapped offsets such as 0x10 and 0x3C within reach next to the four mapped words. Non-aligned addresses such as 0x02, 0x05 and 0x0B show that the low two bits do not affect the decode. The fixed 32-bit data path with four strobes lets partial-lane merges on control and lane-masked clears on the flag word be checked bit for bit.

// File: rtl/apbw_pkg.sv
package apbw_pkg;

    localparam int BUS_W    = 32;
    localparam int LANES    = BUS_W / 8;
    localparam int NUM_REGS = 4;

    typedef logic [BUS_W-1:0] word_t;
    typedef logic [LANES-1:0] lanes_t;

    // Word index of each register; the decoder keys on these.
    typedef enum logic [1:0] {
        RID_CTRL  = 2'd0,
        RID_STAT  = 2'd1,
        RID_IFLAG = 2'd2,
        RID_CMD   = 2'd3
    } reg_id_e;

    // Sequencer phase: ACK is the single completing cycle.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACK  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [NUM_REGS-1:0] onehot;
        logic                miss;
    } decode_t;

    typedef struct packed {
        logic done;
        logic wr;
        logic rd;
    } xfer_t;

    // Expand one strobe bit per lane into a full-width bit mask.
    function automatic word_t lane_mask(input lanes_t strb);
        word_t m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{strb[i]}};
        end
        return m;
    endfunction

    // Take new bytes only on lanes whose strobe is set.
    function automatic word_t lane_merge(input word_t cur, input word_t nxt,
                                         input lanes_t strb);
        word_t m;
        m = lane_mask(strb);
        return (cur & ~m) | (nxt & m);
    endfunction

endpackage

// File: rtl/apbw_decode.sv
module apbw_decode
    import apbw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic [ADDR_W-1:0] paddr,
    output decode_t           dec
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    word_idx;
    logic [NUM_REGS-1:0] hit;

    assign word_idx = paddr[ADDR_W-1:2];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = psel && (word_idx == IDX_W'(g));
    end

    always_comb begin
        dec        = '0;
        dec.onehot = hit;
        dec.miss   = psel && (hit == '0);
    end

endmodule

// File: rtl/apbw_handshake.sv
module apbw_handshake
    import apbw_pkg::*;
(
    input  logic  clk,
    input  logic  presetn,
    input  logic  psel,
    input  logic  penable,
    input  logic  pwrite,
    output logic  pready,
    output xfer_t xf
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = PH_IDLE;
        unique case (phase_q)
            PH_IDLE: phase_d = (psel && penable) ? PH_ACK : PH_IDLE;
            PH_ACK:  phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!presetn) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Ready is a pure decode of the phase register: no input-to-output path.
    assign pready = (phase_q == PH_ACK);

    always_comb begin
        xf      = '0;
        xf.done = pready && psel && penable;
        xf.wr   = xf.done && pwrite;
        xf.rd   = xf.done && !pwrite;
    end

endmodule

// File: rtl/apbw_regbank.sv
module apbw_regbank
    import apbw_pkg::*;
(
    input  logic                clk,
    input  logic                presetn,
    input  xfer_t               xf,
    input  logic [NUM_REGS-1:0] sel,
    input  word_t               pwdata,
    input  lanes_t              pstrb,
    input  word_t               hw_status,
    input  logic                hw_event,
    output word_t               ctrl_q,
    output word_t               stat_q,
    output word_t               iflag_q,
    output logic                cmd_strobe
);
    logic  wr_ctrl, wr_iflag, wr_cmd;
    word_t iflag_d;

    assign wr_ctrl  = xf.wr && sel[RID_CTRL];
    assign wr_iflag = xf.wr && sel[RID_IFLAG];
    assign wr_cmd   = xf.wr && sel[RID_CMD];

    always_comb begin
        iflag_d = iflag_q;
        if (wr_iflag) begin
            iflag_d = iflag_q & ~(lane_mask(pstrb) & pwdata);
        end
        if (hw_event) begin
            iflag_d[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!presetn) begin
            ctrl_q     <= '0;
            stat_q     <= '0;
            iflag_q    <= '0;
            cmd_strobe <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= lane_merge(ctrl_q, pwdata, pstrb);
            end
            stat_q     <= hw_status;
            iflag_q    <= iflag_d;
            cmd_strobe <= wr_cmd;
        end
    end

endmodule

// File: rtl/apbw_slave.sv
module apbw_slave
    import apbw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   presetn,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [apbw_pkg::BUS_W-1:0] pwdata,
    input  logic [apbw_pkg::LANES-1:0] pstrb,
    output logic [apbw_pkg::BUS_W-1:0] prdata,
    output logic                   pready,
    output logic                   pslverr,
    input  logic [apbw_pkg::BUS_W-1:0] hw_status,
    input  logic                   hw_event,
    output logic [apbw_pkg::BUS_W-1:0] ctrl_out,
    output logic                   cmd_strobe
);
    decode_t dec;
    xfer_t   xf;
    word_t   ctrl_q, stat_q, iflag_q;

    apbw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel  (psel),
        .paddr (paddr),
        .dec   (dec)
    );

    apbw_handshake u_hs (
        .clk     (clk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .pready  (pready),
        .xf      (xf)
    );

    apbw_regbank u_bank (
        .clk        (clk),
        .presetn    (presetn),
        .xf         (xf),
        .sel        (dec.onehot),
        .pwdata     (pwdata),
        .pstrb      (pstrb),
        .hw_status  (hw_status),
        .hw_event   (hw_event),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q),
        .iflag_q    (iflag_q),
        .cmd_strobe (cmd_strobe)
    );

    // Read mux: zero unless a readable register is selected.
    always_comb begin
        prdata = '0;
        unique case (1'b1)
            dec.onehot[RID_CTRL]:  prdata = ctrl_q;
            dec.onehot[RID_STAT]:  prdata = stat_q;
            dec.onehot[RID_IFLAG]: prdata = iflag_q;
            default:               prdata = '0;
        endcase
    end

    assign pslverr  = xf.done && dec.miss;
    assign ctrl_out = ctrl_q;

endmodule

// File: rtl/apbw_slave_chk.sv
module apbw_slave_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [31:0]       hw_status,
    input logic [31:0]       ctrl_out,
    input logic              cmd_strobe
);
    logic              fin;
    logic [ADDR_W-3:0] widx;
    assign fin  = psel && penable && pready;
    assign widx = paddr[ADDR_W-1:2];

    // R2
    wait_then_ready_chk: assert property (@(posedge clk) disable iff (!presetn)
        (psel && penable && !pready) |=> pready);

    // R2
    ready_single_chk: assert property (@(posedge clk) disable iff (!presetn)
        pready |=> !pready);

    // R9
    err_on_finish_chk: assert property (@(posedge clk) disable iff (!presetn)
        pslverr |-> (fin && widx > 3));

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!presetn)
        cmd_strobe |=> !cmd_strobe);

    // R5
    status_read_chk: assert property (@(posedge clk) disable iff (!presetn)
        (fin && !pwrite && widx == 1) |-> (prdata == $past(hw_status)));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!presetn)
        (psel && !pwrite && widx > 3) |-> (prdata == '0));

    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!presetn)
        !(fin && pwrite && widx == 0) |=> $stable(ctrl_out));

endmodule

bind apbw_slave apbw_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .presetn    (presetn),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .prdata     (prdata),
    .pready     (pready),
    .pslverr    (pslverr),
    .hw_status  (hw_status),
    .ctrl_out   (ctrl_out),
    .cmd_strobe (cmd_strobe)
);

// File: tb/test_apbw_slave.sv
module test_apbw_slave;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [3:0]    pstrb = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic [31:0]   hw_status = '0;
    logic          hw_event = 1'b0;
    logic [31:0]   ctrl_out;
    logic          cmd_strobe;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ctrl_exp = '0;

    always #5 clk = ~clk;

    apbw_slave #(.ADDR_W(AW)) i_apbw_slave (
        .clk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .hw_status(hw_status), .hw_event(hw_event),
        .ctrl_out(ctrl_out), .cmd_strobe(cmd_strobe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer; returns in the completing cycle (psel/penable still high).
    task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd,
                        output logic err, output logic err_early, output int waits);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        waits = 0;
        #1;
        err_early = pslverr;
        while (!pready && waits < 8) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rd  = prdata;
        err = pslverr;
    endtask

    task automatic idle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 pready", {31'b0, pready}, 0);
        check("R1 pslverr", {31'b0, pslverr}, 0);
        check("R1 prdata", prdata, 0);
        check("R1 ctrl_out", ctrl_out, 0);
        check("R1 cmd_strobe", {31'b0, cmd_strobe}, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] rd; logic e, ee; int w;
        xfer(1, 6'h00, 32'hA1B2C3D4, 4'hF, rd, e, ee, w); idle();
        check("R2 write waits", w, 1);
        ctrl_exp = 32'hA1B2C3D4;
        check("R4 full write", ctrl_out, ctrl_exp);
        xfer(1, 6'h00, 32'h11223344, 4'b0101, rd, e, ee, w); idle();
        ctrl_exp = 32'hA122C344;
        check("R4 lane merge", ctrl_out, ctrl_exp);
        xfer(0, 6'h02, 0, 0, rd, e, ee, w); idle();
        check("R3 R8 read ctrl via 0x02", rd, ctrl_exp);
        check("R2 read waits", w, 1);
        check("R9 no err ctrl", {31'b0, e}, 0);
    endtask

    task automatic t_status();
        logic [31:0] rd; logic e, ee; int w;
        @(negedge clk); hw_status = 32'h5A5A0001;
        xfer(0, 6'h05, 0, 0, rd, e, ee, w); idle();
        check("R5 status read", rd, 32'h5A5A0001);
        xfer(1, 6'h04, 32'hFFFFFFFF, 4'hF, rd, e, ee, w); idle();
        check("R5 status write no err", {31'b0, e}, 0);
        xfer(0, 6'h04, 0, 0, rd, e, ee, w); idle();
        check("R5 status unchanged", rd, 32'h5A5A0001);
        check("R5 ctrl untouched", ctrl_out, ctrl_exp);
    endtask

    task automatic t_iflag();
        logic [31:0] rd; logic e, ee; int w;
        @(negedge clk); hw_event = 1'b1;
        @(negedge clk); hw_event = 1'b0;
        xfer(0, 6'h0B, 0, 0, rd, e, ee, w); idle();
        check("R6 event sets bit0", rd, 1);
        xfer(1, 6'h08, 32'h1, 4'h0, rd, e, ee, w); idle();
        xfer(0, 6'h08, 0, 0, rd, e, ee, w); idle();
        check("R6 masked lane no clear", rd, 1);
        @(negedge clk); hw_event = 1'b1;
        xfer(1, 6'h08, 32'h1, 4'h1, rd, e, ee, w); idle();
        hw_event = 1'b0;
        xfer(0, 6'h08, 0, 0, rd, e, ee, w); idle();
        check("R6 set wins over clear", rd, 1);
        xfer(1, 6'h08, 32'hFFFFFFFF, 4'h1, rd, e, ee, w); idle();
        xfer(0, 6'h08, 0, 0, rd, e, ee, w); idle();
        check("R6 write-one clears", rd, 0);
    endtask

    task automatic t_cmd();
        logic [31:0] rd; logic e, ee; int w;
        xfer(1, 6'h0C, 32'h1, 4'hF, rd, e, ee, w);
        check("R7 no strobe in completing cycle", {31'b0, cmd_strobe}, 0);
        idle(); #1;
        check("R7 strobe after completion", {31'b0, cmd_strobe}, 1);
        @(negedge clk); #1;
        check("R7 strobe one cycle", {31'b0, cmd_strobe}, 0);
        xfer(0, 6'h0C, 0, 0, rd, e, ee, w); idle();
        check("R7 command reads zero", rd, 0);
        check("R7 command read no err", {31'b0, e}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; logic e, ee; int w;
        xfer(0, 6'h10, 0, 0, rd, e, ee, w); idle();
        check("R8 unmapped read zero", rd, 0);
        check("R9 unmapped read err", {31'b0, e}, 1);
        check("R9 no err in wait cycle", {31'b0, ee}, 0);
        xfer(1, 6'h3C, 32'h0BADF00D, 4'hF, rd, e, ee, w); idle();
        check("R9 unmapped write err", {31'b0, e}, 1);
        check("R9 unmapped write harmless", ctrl_out, ctrl_exp);
        #1;
        check("R9 err low when idle", {31'b0, pslverr}, 0);
    endtask

    task automatic t_abort();
        logic [31:0] rd; logic e, ee; int w;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 6'h00;
        pwdata = 32'hDEADBEEF; pstrb = 4'hF;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 abort no commit", ctrl_out, ctrl_exp);
        xfer(0, 6'h00, 0, 0, rd, e, ee, w); idle();
        check("R10 next transfer waits", w, 1);
        check("R10 read after abort", rd, ctrl_exp);
    endtask

    task automatic t_b2b();
        logic [31:0] rd; logic e, ee; int w1, w2;
        xfer(1, 6'h00, 32'h0000FFFF, 4'b0011, rd, e, ee, w1);
        xfer(0, 6'h00, 0, 0, rd, e, ee, w2); idle();
        ctrl_exp = {ctrl_exp[31:16], 16'hFFFF};
        check("R11 first waits", w1, 1);
        check("R11 second waits", w2, 1);
        check("R11 back-to-back read", rd, ctrl_exp);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); presetn = 1'b1;
        t_ctrl();
        t_status();
        t_iflag();
        t_cmd();
        t_unmapped();
        t_abort();
        t_b2b();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule